// File: doc/BRIEF.md
# Transactional Rename Checkpoint Unit

This block keeps the architectural-to-physical register map of an out-of-order core and lets that core run hardware transactions back to back. Each physical register carries a saved flag that marks whether the live map currently points at it. Renaming moves the flag from the displaced register to the newly allocated one, so exactly as many flags are set as there are architectural registers. New registers come from a bit-vector free list, and the lowest-numbered free register is always allocated first.

When decode sees a transaction start, the unit copies the map and the saved flags into one of two pending snapshot slots. When that start instruction retires, the oldest pending snapshot becomes the active checkpoint. While a checkpoint is active, a retiring instruction whose displaced register belongs to the checkpoint's saved set parks that register on a reserved list instead of freeing it. This keeps the rollback state intact with a fixed register cost, however far decode runs ahead into later transactions. Retiring the transaction end releases the reserved registers and closes the checkpoint. An abort rolls the map back to the checkpoint and rebuilds the free list from it.

Top module: `tmr_rename_ckpt`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers NARCH..NPHYS-1 are free, so the first allocation returns NARCH.
- R2: An accepted rename of kind 1 (dec_kind=1) allocates the lowest-numbered free physical register on dec_new_preg. In the same cycle, dec_old_preg shows the previous mapping of dec_dst. From the next cycle, a lookup of that architectural register returns the new register. dec_src_preg always shows the current mapping of dec_src.
- R3: The saved set always holds exactly NARCH registers. Once nothing is in flight and no checkpoint is active, exactly NPHYS-NARCH allocations succeed before decode stalls.
- R4: dec_ready is low for a rename (kind 1) when no register is free. It is low for a transaction start (kind 2) when both pending snapshot slots are occupied. It is low for any kind during an abort. It is high for kinds 0 and 3 otherwise.
- R5: An accepted transaction start captures the map and the saved flags as it stands before that cycle. A retiring transaction start (ret_kind=2) makes the oldest pending snapshot active, in decode order.
- R6: A retiring rename (ret_kind=1) whose ret_old_preg lies in the active checkpoint's saved set is reserved. It is not allocated again until the checkpoint closes.
- R7: A retiring rename with no active checkpoint, or whose old register lies outside the checkpoint's saved set, returns that register to the free list in the next cycle.
- R8: A retiring transaction end (ret_kind=3) moves every reserved register to the free list and closes the active checkpoint.
- R9: An abort while a checkpoint is active restores the map and saved flags from the checkpoint. It sets the free list to every register outside the checkpoint's saved set, empties the reserved list and the pending slots, and closes the checkpoint. Decode and retire inputs are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_kind | input | 2 | 0 plain, 1 rename destination, 2 transaction start, 3 transaction end |
| dec_dst | input | AW | Destination architectural register |
| dec_src | input | AW | Source architectural register to look up |
| dec_ready | output | 1 | Decode instruction accepted this cycle when valid |
| dec_src_preg | output | PW | Current mapping of dec_src |
| dec_new_preg | output | PW | Register allocated for dec_dst |
| dec_old_preg | output | PW | Mapping of dec_dst being displaced |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_kind | input | 2 | Kind of the retiring instruction, same encoding as dec_kind |
| ret_old_preg | input | PW | Displaced register carried by a retiring rename |
| abort | input | 1 | Roll back to the active checkpoint and flush |

## Verification
A reference model in the bench follows the map, the saved set, the free list, the reserved list and the snapshot queue. It predicts every allocation and lookup. Directed runs exhaust the free list, fill both pending slots, and abort after two transactions have been decoded, which tells whether the restored map comes from the oldest snapshot or the youngest. Another directed run reserves registers inside a transaction and then drains the free list, so a reserved register handed out early shows up as a wrong allocation. Constrained random traffic mixes long and short transactions, retire gaps and aborts. A final drain counts the allocations left, which exposes any leak or duplication of registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_DST    = 2'd1,
    OP_TBEGIN = 2'd2,
    OP_TEND   = 2'd3
  } tmr_op_e;
endpackage

// File: rtl/tmr_freelist.sv
module tmr_freelist #(
  parameter int NPHYS = 32,
  parameter int NLIVE = 8,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [NPHYS-1:0] rel_mask,
  input  logic             load_en,
  input  logic [NPHYS-1:0] load_mask,
  output logic [NPHYS-1:0] free_vec,
  output logic             alloc_ok,
  output logic [PW-1:0]    alloc_idx
);
  localparam logic [NPHYS-1:0] RST_FREE = {NPHYS{1'b1}} << NLIVE;
  localparam logic [NPHYS-1:0] ONE      = NPHYS'(1);

  logic [NPHYS-1:0] free_q, free_d, take_mask;
  logic             upd;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    alloc_idx = '0;
    for (int i = NPHYS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_idx = PW'(i);
    end
  end

  assign alloc_ok  = |free_q;
  assign take_mask = alloc_en ? (ONE << alloc_idx) : '0;
  assign upd       = load_en | alloc_en | (|rel_mask);

  always_comb begin
    if (load_en) free_d = load_mask;
    else         free_d = (free_q & ~take_mask) | rel_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   free_q <= RST_FREE;
    else if (upd) free_q <= free_d;
  end

  assign free_vec = free_q;
endmodule

// File: rtl/tmr_maptable.sv
module tmr_maptable #(
  parameter int NARCH = 8,
  parameter int NPHYS = 32,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ren_en,
  input  logic [AW-1:0]              ren_dst,
  input  logic [PW-1:0]              ren_preg,
  input  logic                       restore_en,
  input  logic [NARCH-1:0][PW-1:0]   restore_map,
  input  logic [NPHYS-1:0]           restore_saved,
  input  logic [AW-1:0]              rd_a,
  input  logic [AW-1:0]              rd_b,
  output logic [PW-1:0]              rd_a_preg,
  output logic [PW-1:0]              rd_b_preg,
  output logic [NARCH-1:0][PW-1:0]   map_vec,
  output logic [NPHYS-1:0]           saved_vec
);
  localparam logic [NPHYS-1:0] RST_SAVED = ~({NPHYS{1'b1}} << NARCH);

  logic [PW-1:0]    map_q [NARCH];
  logic [NPHYS-1:0] saved_q, saved_d;
  logic             saved_upd;

  for (genvar a = 0; a < NARCH; a++) begin : g_ent
    logic          we;
    logic [PW-1:0] nxt;
    assign we  = restore_en | (ren_en && (ren_dst == AW'(a)));
    assign nxt = restore_en ? restore_map[a] : ren_preg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  map_q[a] <= PW'(a);
      else if (we) map_q[a] <= nxt;
    end
    assign map_vec[a] = map_q[a];
  end

  always_comb begin
    saved_d = saved_q;
    if (restore_en) begin
      saved_d = restore_saved;
    end else if (ren_en) begin
      saved_d[map_q[ren_dst]] = 1'b0;
      saved_d[ren_preg]       = 1'b1;
    end
  end

  assign saved_upd = restore_en | ren_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         saved_q <= RST_SAVED;
    else if (saved_upd) saved_q <= saved_d;
  end

  assign rd_a_preg = map_q[rd_a];
  assign rd_b_preg = map_q[rd_b];
  assign saved_vec = saved_q;
endmodule

// File: rtl/tmr_snapq.sv
module tmr_snapq #(
  parameter int NARCH = 8,
  parameter int NPHYS = 32,
  parameter int NPEND = 2,
  localparam int PW   = $clog2(NPHYS),
  localparam int PTRW = (NPEND > 1) ? $clog2(NPEND) : 1,
  localparam int CW   = $clog2(NPEND + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_en,
  input  logic [NARCH-1:0][PW-1:0] push_map,
  input  logic [NPHYS-1:0]         push_saved,
  input  logic                     activate_en,
  input  logic                     close_en,
  input  logic                     park_en,
  input  logic [PW-1:0]            park_idx,
  input  logic                     flush_en,
  output logic                     pend_full,
  output logic                     pend_empty,
  output logic                     act_valid,
  output logic [NARCH-1:0][PW-1:0] act_map,
  output logic [NPHYS-1:0]         act_saved,
  output logic [NPHYS-1:0]         resv_vec
);
  logic [NARCH-1:0][PW-1:0] slot_map   [NPEND];
  logic [NPHYS-1:0]         slot_saved [NPEND];

  logic [PTRW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             actv_q, actv_d;
  logic [NPHYS-1:0] resv_q, resv_d;
  logic             pop;

  function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
    return (p == PTRW'(NPEND - 1)) ? '0 : p + PTRW'(1);
  endfunction

  for (genvar s = 0; s < NPEND; s++) begin : g_slot
    logic we;
    assign we = push_en && !flush_en && (wr_q == PTRW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_map[s]   <= '0;
        slot_saved[s] <= '0;
      end else if (we) begin
        slot_map[s]   <= push_map;
        slot_saved[s] <= push_saved;
      end
    end
  end

  assign pop = activate_en && !flush_en && (cnt_q != '0);

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    actv_d = actv_q;
    resv_d = resv_q;
    if (flush_en) begin
      wr_d   = '0;
      rd_d   = '0;
      cnt_d  = '0;
      actv_d = 1'b0;
      resv_d = '0;
    end else begin
      if (push_en) wr_d = ptr_inc(wr_q);
      if (pop)     rd_d = ptr_inc(rd_q);
      cnt_d = cnt_q + CW'(push_en) - CW'(pop);
      if (pop) actv_d = 1'b1;
      if (close_en) begin
        actv_d = 1'b0;
        resv_d = '0;
      end
      if (park_en) resv_d[park_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      actv_q <= 1'b0;
      resv_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      actv_q <= actv_d;
      resv_q <= resv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_map   <= '0;
      act_saved <= '0;
    end else if (pop) begin
      act_map   <= slot_map[rd_q];
      act_saved <= slot_saved[rd_q];
    end
  end

  assign pend_full  = (cnt_q == CW'(NPEND));
  assign pend_empty = (cnt_q == '0);
  assign act_valid  = actv_q;
  assign resv_vec   = resv_q;
endmodule

// File: rtl/tmr_rename_ckpt.sv
module tmr_rename_ckpt #(
  parameter int NARCH = 8,
  parameter int NPHYS = 32,
  parameter int NPEND = 2,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [1:0]    dec_kind,
  input  logic [AW-1:0] dec_dst,
  input  logic [AW-1:0] dec_src,
  output logic          dec_ready,
  output logic [PW-1:0] dec_src_preg,
  output logic [PW-1:0] dec_new_preg,
  output logic [PW-1:0] dec_old_preg,
  input  logic          ret_valid,
  input  logic [1:0]    ret_kind,
  input  logic [PW-1:0] ret_old_preg,
  input  logic          abort
);
  import tmr_pkg::*;

  localparam logic [NPHYS-1:0] ONE = NPHYS'(1);

  tmr_op_e dec_op, ret_op;
  logic    dec_fire, ren_en, push_en;
  logic    ret_act, ret_dst, park_en, activate_en, close_en, restore_en;
  logic    alloc_ok, pend_full, pend_empty, act_valid;

  logic [NPHYS-1:0]         free_vec, saved_vec, act_saved, resv_vec;
  logic [NPHYS-1:0]         rel_mask, ret_free_mask;
  logic [NARCH-1:0][PW-1:0] map_vec, act_map;
  logic [PW-1:0]            alloc_idx;

  assign dec_op = tmr_op_e'(dec_kind);
  assign ret_op = tmr_op_e'(ret_kind);

  always_comb begin
    if (abort) begin
      dec_ready = 1'b0;
    end else begin
      case (dec_op)
        OP_DST:    dec_ready = alloc_ok;
        OP_TBEGIN: dec_ready = !pend_full;
        default:   dec_ready = 1'b1;
      endcase
    end
  end

  assign dec_fire = dec_valid && dec_ready;
  assign ren_en   = dec_fire && (dec_op == OP_DST);
  assign push_en  = dec_fire && (dec_op == OP_TBEGIN);

  assign ret_act     = ret_valid && !abort;
  assign ret_dst     = ret_act && (ret_op == OP_DST);
  assign activate_en = ret_act && (ret_op == OP_TBEGIN);
  assign close_en    = ret_act && (ret_op == OP_TEND);
  assign park_en     = ret_dst && act_valid && act_saved[ret_old_preg];

  assign ret_free_mask = (ret_dst && !park_en) ? (ONE << ret_old_preg) : '0;
  assign rel_mask      = ret_free_mask | (close_en ? resv_vec : '0);
  assign restore_en    = abort && act_valid;

  tmr_freelist #(.NPHYS(NPHYS), .NLIVE(NARCH)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (ren_en),
    .rel_mask  (rel_mask),
    .load_en   (restore_en),
    .load_mask (~act_saved),
    .free_vec  (free_vec),
    .alloc_ok  (alloc_ok),
    .alloc_idx (alloc_idx)
  );

  tmr_maptable #(.NARCH(NARCH), .NPHYS(NPHYS)) u_map (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_en        (ren_en),
    .ren_dst       (dec_dst),
    .ren_preg      (alloc_idx),
    .restore_en    (restore_en),
    .restore_map   (act_map),
    .restore_saved (act_saved),
    .rd_a          (dec_src),
    .rd_b          (dec_dst),
    .rd_a_preg     (dec_src_preg),
    .rd_b_preg     (dec_old_preg),
    .map_vec       (map_vec),
    .saved_vec     (saved_vec)
  );

  tmr_snapq #(.NARCH(NARCH), .NPHYS(NPHYS), .NPEND(NPEND)) u_snap (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en     (push_en),
    .push_map    (map_vec),
    .push_saved  (saved_vec),
    .activate_en (activate_en),
    .close_en    (close_en),
    .park_en     (park_en),
    .park_idx    (ret_old_preg),
    .flush_en    (abort),
    .pend_full   (pend_full),
    .pend_empty  (pend_empty),
    .act_valid   (act_valid),
    .act_map     (act_map),
    .act_saved   (act_saved),
    .resv_vec    (resv_vec)
  );

  assign dec_new_preg = alloc_idx;
endmodule

// File: rtl/tmr_rename_ckpt_chk.sv
module tmr_rename_ckpt_chk #(
  parameter int NARCH = 8,
  parameter int NPHYS = 32,
  localparam int PW = $clog2(NPHYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ren_en,
  input logic             park_en,
  input logic             close_en,
  input logic             activate_en,
  input logic             restore_en,
  input logic             pend_full,
  input logic             pend_empty,
  input logic             act_valid,
  input logic             dec_valid,
  input logic [1:0]       dec_kind,
  input logic             dec_ready,
  input logic [PW-1:0]    dec_new_preg,
  input logic [PW-1:0]    dec_old_preg,
  input logic [PW-1:0]    ret_old_preg,
  input logic [NPHYS-1:0] free_vec,
  input logic [NPHYS-1:0] saved_vec,
  input logic [NPHYS-1:0] resv_vec,
  input logic [NPHYS-1:0] act_saved
);
  // R3
  saved_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(saved_vec) == NARCH);

  // R2
  alloc_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en |-> (free_vec[dec_new_preg] && !saved_vec[dec_new_preg]));

  // R2
  saved_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en |=> (saved_vec[$past(dec_new_preg)] && !saved_vec[$past(dec_old_preg)]));

  // R4
  begin_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'd2 && pend_full) |-> !dec_ready);

  // R5
  activate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (activate_en && !pend_empty && !restore_en) |=> act_valid);

  // R6
  resv_free_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_vec & free_vec) == '0);

  // R6
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |=> (resv_vec[$past(ret_old_preg)] && !free_vec[$past(ret_old_preg)]));

  // R8
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |=> (!act_valid && resv_vec == '0));

  // R9
  restore_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (free_vec == ~$past(act_saved) && !act_valid && resv_vec == '0));
endmodule

bind tmr_rename_ckpt tmr_rename_ckpt_chk #(.NARCH(NARCH), .NPHYS(NPHYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ren_en       (ren_en),
  .park_en      (park_en),
  .close_en     (close_en),
  .activate_en  (activate_en),
  .restore_en   (restore_en),
  .pend_full    (pend_full),
  .pend_empty   (pend_empty),
  .act_valid    (act_valid),
  .dec_valid    (dec_valid),
  .dec_kind     (dec_kind),
  .dec_ready    (dec_ready),
  .dec_new_preg (dec_new_preg),
  .dec_old_preg (dec_old_preg),
  .ret_old_preg (ret_old_preg),
  .free_vec     (free_vec),
  .saved_vec    (saved_vec),
  .resv_vec     (resv_vec),
  .act_saved    (act_saved)
);

// File: tb/tb_tmr_rename_ckpt.sv
`timescale 1ns/1ps
module tb_tmr_rename_ckpt;
  localparam int NARCH = 8;
  localparam int NPHYS = 32;
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dec_valid, ret_valid, abort, dec_ready;
  logic [1:0]    dec_kind, ret_kind;
  logic [AW-1:0] dec_dst, dec_src;
  logic [PW-1:0] dec_src_preg, dec_new_preg, dec_old_preg, ret_old_preg;

  always #5 clk = ~clk;

  tmr_rename_ckpt #(.NARCH(NARCH), .NPHYS(NPHYS), .NPEND(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_dst(dec_dst), .dec_src(dec_src),
    .dec_ready(dec_ready), .dec_src_preg(dec_src_preg), .dec_new_preg(dec_new_preg),
    .dec_old_preg(dec_old_preg), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .ret_old_preg(ret_old_preg), .abort(abort)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  int         m_map [NARCH];
  bit [NPHYS-1:0] m_saved, m_free, m_resv;
  int         pend_map [2][NARCH];
  bit [NPHYS-1:0] pend_saved [2];
  int         pend_cnt, ph, pt;
  bit         act_v;
  int         act_map [NARCH];
  bit [NPHYS-1:0] act_saved;
  int         why [NPHYS];
  int         rob_k [64], rob_o [64];
  int         rh, rt, rcnt;
  bit         in_txn, last_rdy;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest(input bit [NPHYS-1:0] v);
    for (int i = 0; i < NPHYS; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic string tagof(input int w);
    case (w)
      1: return "R1";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NARCH; i++) m_map[i] = i;
    m_saved = '0; m_free = '0; m_resv = '0;
    for (int i = 0; i < NPHYS; i++) begin
      if (i < NARCH) m_saved[i] = 1'b1; else m_free[i] = 1'b1;
      why[i] = 1;
    end
    pend_cnt = 0; ph = 0; pt = 0; act_v = 0; act_saved = '0;
    rh = 0; rt = 0; rcnt = 0; in_txn = 0;
  endtask

  task automatic step(input bit dv, input int dk, input int dd, input int ds,
                      input bit dret, input bit ab, input string stag);
    bit exp_rdy, fired;
    int p, old, rk, ro;
    string t;
    bit [NPHYS-1:0] pre_free;
    @(negedge clk);
    rk = dret ? rob_k[rh] : 0;
    ro = dret ? rob_o[rh] : 0;
    dec_valid = dv; dec_kind = 2'(dk); dec_dst = AW'(dd); dec_src = AW'(ds);
    ret_valid = dret; ret_kind = 2'(rk); ret_old_preg = PW'(ro); abort = ab;
    #1;
    exp_rdy = ab ? 1'b0 : (dk == 1) ? (m_free != '0) : (dk == 2) ? (pend_cnt < 2) : 1'b1;
    last_rdy = dec_ready;
    check(dec_ready == exp_rdy, "R4", int'(dec_ready), int'(exp_rdy));
    check(int'(dec_src_preg) == m_map[ds], stag, int'(dec_src_preg), m_map[ds]);
    fired = dv && exp_rdy;
    p = 0;
    old = m_map[dd];
    if (fired && dk == 1) begin
      p = lowest(m_free);
      t = tagof(why[p]);
      if (int'(dec_new_preg) != p && m_resv[dec_new_preg]) t = "R6";
      check(int'(dec_new_preg) == p, t, int'(dec_new_preg), p);
      check(int'(dec_old_preg) == old, "R2", int'(dec_old_preg), old);
    end
    if (ab) begin
      if (act_v) begin
        pre_free = m_free;
        for (int i = 0; i < NARCH; i++) m_map[i] = act_map[i];
        m_saved = act_saved;
        m_free = ~act_saved;
        for (int i = 0; i < NPHYS; i++) if (m_free[i] && !pre_free[i]) why[i] = 9;
        m_resv = '0;
        act_v = 0;
      end
      pend_cnt = 0; ph = 0; pt = 0;
      rh = 0; rt = 0; rcnt = 0;
    end else begin
      if (dret) begin
        rh = (rh + 1) % 64; rcnt--;
        case (rk)
          1: if (act_v && act_saved[ro]) m_resv[ro] = 1'b1;
             else begin m_free[ro] = 1'b1; why[ro] = 7; end
          2: if (pend_cnt > 0) begin
               for (int i = 0; i < NARCH; i++) act_map[i] = pend_map[ph][i];
               act_saved = pend_saved[ph];
               act_v = 1; ph = (ph + 1) % 2; pend_cnt--;
             end
          3: begin
               for (int i = 0; i < NPHYS; i++) if (m_resv[i]) begin m_free[i] = 1'b1; why[i] = 8; end
               m_resv = '0; act_v = 0;
             end
          default: ;
        endcase
      end
      if (fired) begin
        rob_k[rt] = dk; rob_o[rt] = (dk == 1) ? old : 0;
        rt = (rt + 1) % 64; rcnt++;
        if (dk == 1) begin
          m_free[p] = 1'b0; m_saved[old] = 1'b0; m_saved[p] = 1'b1; m_map[dd] = p;
        end else if (dk == 2) begin
          for (int i = 0; i < NARCH; i++) pend_map[pt][i] = m_map[i];
          pend_saved[pt] = m_saved;
          pt = (pt + 1) % 2; pend_cnt++;
        end
        if (dk == 2) in_txn = 1;
        if (dk == 3) in_txn = 0;
      end
    end
    if (ab) in_txn = 0;
  endtask

  task automatic check_map(input string tag);
    for (int i = 0; i < NARCH; i++) step(0, 0, 0, i, 0, 0, tag);
  endtask

  task automatic drain();
    while (rcnt > 0) step(0, 0, 0, 0, 1, 0, "R2");
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_71c3));
    rst_n = 1'b0; dec_valid = 0; dec_kind = 0; dec_dst = 0; dec_src = 0;
    ret_valid = 0; ret_kind = 0; ret_old_preg = 0; abort = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity map, first allocations start at NARCH
    check_map("R1");

    // R4: exhaust the free list without retiring
    for (int i = 0; i < NPHYS - NARCH + 1; i++) step(1, 1, i % NARCH, i % NARCH, 0, 0, "R2");
    drain();

    // R5: two transactions decoded, abort picks the oldest snapshot
    step(1, 2, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 1, 0, 0, "R2");
    step(1, 1, 2, 2, 0, 0, "R2");
    step(1, 3, 0, 0, 0, 0, "R2");
    step(1, 2, 0, 0, 0, 0, "R2");
    step(1, 1, 3, 3, 0, 0, "R2");
    step(1, 3, 0, 0, 0, 0, "R2");
    step(1, 2, 0, 0, 0, 0, "R2");   // both slots busy: stall (R4)
    step(0, 0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, 1, "R9");
    check_map("R5");
    step(1, 1, 4, 4, 0, 0, "R9");

    // R6 then R8: reserve inside a transaction, drain free list, then release
    step(1, 2, 0, 0, 0, 0, "R2");
    drain();
    step(1, 1, 0, 0, 0, 0, "R2");
    step(1, 1, 5, 5, 0, 0, "R2");
    drain();
    for (int i = 0; i < 30; i++) step(1, 1, i % NARCH, i % NARCH, 0, 0, "R2");
    step(1, 3, 0, 0, 0, 0, "R2");
    drain();
    for (int i = 0; i < 10; i++) step(1, 1, i % NARCH, 0, 0, 0, "R2");
    drain();

    // constrained random traffic
    for (int c = 0; c < 5000; c++) begin
      bit ab, dret, dv;
      int dk, r;
      ab = act_v && ($urandom % 40 == 0);
      dret = !ab && rcnt > 0 && ($urandom % 3 != 0);
      dv = (rcnt < 60) && ($urandom % 4 != 0);
      r = $urandom % 16;
      if (in_txn) dk = (r < 2) ? 3 : (r < 4) ? 0 : 1;
      else        dk = (r < 3) ? 2 : (r < 5) ? 0 : 1;
      step(dv, dk, $urandom % NARCH, $urandom % NARCH, dret, ab, "R2");
    end

    // R3: after quiescing, exactly NPHYS-NARCH allocations remain
    if (in_txn) step(1, 3, 0, 0, 0, 0, "R2");
    drain();
    n = 0;
    for (int i = 0; i < NPHYS - NARCH; i++) begin
      step(1, 1, i % NARCH, 0, 0, 0, "R2");
      if (last_rdy) n++;
    end
    step(1, 1, 0, 0, 0, 0, "R2");
    check(n == NPHYS - NARCH && !last_rdy, "R3", n, NPHYS - NARCH);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule